// File: doc/BRIEF.md
# Packet-Aware Sample Width Adapter

This block joins two streaming video interfaces whose per-sample bit depth differs. Each beat carries `PIXELS` pixels of `PLANES` color samples. On beats of video packets, every sample is narrowed by dropping its least significant bits or widened by appending zero bits below it. Beats of non-video (auxiliary) packets keep their payload. The one exception is the active-bits-per-color field of an image information packet. When the adapter narrows, it lowers that field so it never advertises more bits than the output carries.

The adapter is purely combinational on the data path. Valid, ready, last and the side-band user bits pass straight through, and backpressure reaches the upstream side in the same cycle. A small packet tracker records the kind of the current packet from its first beat. An optional write port sets the depth the adapter advertises. A new value written there is picked up only at the first beat of the next packet.

Top module: `swa_adapter`

## Requirements
- R1: When `IN_BPS > OUT_BPS`, each output sample of a video beat equals the upper `OUT_BPS` bits of the matching input sample.
- R2: When `IN_BPS < OUT_BPS`, each output sample of a video beat is the input sample in its upper bits, followed by `OUT_BPS-IN_BPS` zero bits.
- R3: Sample lane k, where k = pixel*PLANES+plane, occupies bits `[k*BPS +: BPS]` on both sides. Every lane of a beat receives the same conversion.
- R4: A packet is auxiliary when `s_tuser[1]` is 1 on its first beat. Otherwise it is video. The kind holds until the beat with `s_tlast` is accepted. An auxiliary packet whose first beat has `s_tdata[3:0] == 4'h1` is an image information packet.
- R5: On auxiliary beats, output bits `[PASS_W-1:0]` equal input bits `[PASS_W-1:0]`, where `PASS_W = min(IN_W, OUT_W)`. Any higher output bits are zero. The field in R6 is the only exception.
- R6: When narrowing, the field at bits `[12:8]` of beat index 1 of an image information packet leaves as min(incoming value, packet limit). The same bits in other auxiliary packets are unchanged.
- R7: When widening, the image information field passes unchanged.
- R8: The limit register resets to `OUT_BPS`. A `cfg_wr` pulse loads `cfg_wdata`. The packet limit is min(register, `OUT_BPS`), sampled when the first beat of a packet is accepted. A write made during a packet affects only later packets.
- R9: `m_tvalid`, `m_tlast`, `m_tuser` follow the `s_` inputs and `s_tready` follows `m_tready` in the same cycle, including during reset.
- R10: A beat presented while `m_tready` is low does not advance packet tracking. The beat index counts accepted beats only.
- R11: With `HAS_CTRL = 0`, `cfg_wr` has no effect and the limit is always `OUT_BPS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | IN_BPS*PLANES*PIXELS | Upstream data |
| s_tvalid | input | 1 | Upstream valid |
| s_tready | output | 1 | Upstream ready (equals m_tready) |
| s_tlast | input | 1 | Last beat of packet |
| s_tuser | input | 2 | bit0 start of frame, bit1 auxiliary flag on first beat |
| m_tdata | output | OUT_BPS*PLANES*PIXELS | Downstream data |
| m_tvalid | output | 1 | Downstream valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Last beat of packet |
| m_tuser | output | 2 | Side-band bits, passed through |
| cfg_wr | input | 1 | Limit register write strobe |
| cfg_wdata | input | FIELD_W | Limit register write value |

## Verification
Two events can coincide: a register write and an image information packet in flight whose field beat has not yet been accepted. The bench writes a new limit between beat 0 and beat 1 of such a packet. It expects that field to still be clamped by the old limit, and the next packet to use the new one. A second instance without the register shares the same stimulus and must always clamp to `OUT_BPS`. Stalls placed on the first beat of an information packet check that the field is found on the right beat.

// File: rtl/swa_pkg.sv
package swa_pkg;

    typedef enum logic [1:0] {
        PK_VIDEO = 2'd0,
        PK_AUX   = 2'd1,
        PK_INFO  = 2'd2
    } pkt_kind_e;

    localparam int TUSER_W = 2;
    localparam int AUX_BIT = 1;
    localparam int CODE_W  = 4;
    localparam logic [CODE_W-1:0] INFO_CODE = 4'h1;

    typedef struct packed {
        pkt_kind_e kind;
        logic      first;
        logic      field_beat;
    } beat_class_t;

    function automatic int min_i(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic pkt_kind_e decode_kind(input logic aux, input logic [CODE_W-1:0] code);
        if (!aux)
            return PK_VIDEO;
        else if (code == INFO_CODE)
            return PK_INFO;
        else
            return PK_AUX;
    endfunction

endpackage

// File: rtl/swa_classifier.sv
module swa_classifier
    import swa_pkg::*;
#(
    parameter int INFO_BEAT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              last,
    input  logic              aux_flag,
    input  logic [CODE_W-1:0] code,
    output beat_class_t       cls
);
    localparam int CNT_W = $clog2(INFO_BEAT + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(INFO_BEAT + 1);
    localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(INFO_BEAT);

    logic             in_pkt_q;
    pkt_kind_e        kind_q;
    logic [CNT_W-1:0] idx_q;

    always_comb begin
        cls.first      = !in_pkt_q;
        cls.kind       = in_pkt_q ? kind_q : decode_kind(aux_flag, code);
        cls.field_beat = (cls.kind == PK_INFO) && (idx_q == CNT_HIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt_q <= 1'b0;
            kind_q   <= PK_VIDEO;
            idx_q    <= '0;
        end else if (accept) begin
            if (last) begin
                in_pkt_q <= 1'b0;
                idx_q    <= '0;
            end else begin
                in_pkt_q <= 1'b1;
                kind_q   <= cls.kind;
                if (idx_q != CNT_MAX)
                    idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/swa_lane_map.sv
module swa_lane_map #(
    parameter int IN_BPS  = 10,
    parameter int OUT_BPS = 8,
    parameter int LANES   = 6
) (
    input  logic [IN_BPS*LANES-1:0]  din,
    output logic [OUT_BPS*LANES-1:0] dout
);
    localparam int DIFF = (IN_BPS > OUT_BPS) ? IN_BPS - OUT_BPS : OUT_BPS - IN_BPS;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (IN_BPS >= OUT_BPS) begin : g_clip
            assign dout[k*OUT_BPS +: OUT_BPS] = din[k*IN_BPS + DIFF +: OUT_BPS];
        end else begin : g_pad
            assign dout[k*OUT_BPS +: OUT_BPS] = {din[k*IN_BPS +: IN_BPS], {DIFF{1'b0}}};
        end
    end
endmodule

// File: rtl/swa_field_fix.sv
module swa_field_fix #(
    parameter int W         = 48,
    parameter int FIELD_LSB = 8,
    parameter int FIELD_W   = 5,
    parameter bit NARROW    = 1'b1
) (
    input  logic [W-1:0]       din,
    input  logic               en,
    input  logic [FIELD_W-1:0] limit,
    output logic [W-1:0]       dout
);
    logic [FIELD_W-1:0] field_in;

    always_comb begin
        field_in = din[FIELD_LSB +: FIELD_W];
        dout     = din;
        if (NARROW && en && (field_in > limit))
            dout[FIELD_LSB +: FIELD_W] = limit;
    end
endmodule

// File: rtl/swa_limit_reg.sv
module swa_limit_reg #(
    parameter bit HAS_CTRL = 1'b1,
    parameter int FIELD_W  = 5,
    parameter int OUT_BPS  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [FIELD_W-1:0] cfg_wdata,
    input  logic               capture,
    output logic [FIELD_W-1:0] limit,
    output logic [FIELD_W-1:0] held
);
    localparam logic [FIELD_W-1:0] MAX_F = FIELD_W'(OUT_BPS);

    logic [FIELD_W-1:0] eff;

    if (HAS_CTRL) begin : g_ctrl
        logic [FIELD_W-1:0] reg_q;
        always_ff @(posedge clk) begin
            if (rst)
                reg_q <= MAX_F;
            else if (cfg_wr)
                reg_q <= cfg_wdata;
        end
        assign eff = (reg_q > MAX_F) ? MAX_F : reg_q;
    end else begin : g_fixed
        assign eff = MAX_F;
    end

    always_ff @(posedge clk) begin
        if (rst)
            held <= MAX_F;
        else if (capture)
            held <= eff;
    end

    assign limit = capture ? eff : held;
endmodule

// File: rtl/swa_adapter.sv
module swa_adapter
    import swa_pkg::*;
#(
    parameter int IN_BPS    = 10,
    parameter int OUT_BPS   = 8,
    parameter int PLANES    = 3,
    parameter int PIXELS    = 2,
    parameter bit HAS_CTRL  = 1'b1,
    parameter int INFO_BEAT = 1,
    parameter int FIELD_LSB = 8,
    parameter int FIELD_W   = 5
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [IN_BPS*PLANES*PIXELS-1:0]  s_tdata,
    input  logic                             s_tvalid,
    output logic                             s_tready,
    input  logic                             s_tlast,
    input  logic [1:0]                       s_tuser,
    output logic [OUT_BPS*PLANES*PIXELS-1:0] m_tdata,
    output logic                             m_tvalid,
    input  logic                             m_tready,
    output logic                             m_tlast,
    output logic [1:0]                       m_tuser,
    input  logic                             cfg_wr,
    input  logic [FIELD_W-1:0]               cfg_wdata
);
    localparam int LANES  = PLANES * PIXELS;
    localparam int IN_W   = IN_BPS * LANES;
    localparam int OUT_W  = OUT_BPS * LANES;
    localparam int PASS_W = min_i(IN_W, OUT_W);
    localparam bit NARROW = (IN_BPS > OUT_BPS);

    beat_class_t        cls;
    logic               accept;
    logic               first_acc;
    logic [FIELD_W-1:0] limit;
    logic [FIELD_W-1:0] held_limit;
    logic [OUT_W-1:0]   video_out;
    logic [PASS_W-1:0]  aux_fixed;
    logic [OUT_W-1:0]   aux_out;

    assign accept    = s_tvalid && m_tready;
    assign first_acc = accept && cls.first;

    assign s_tready = m_tready;
    assign m_tvalid = s_tvalid;
    assign m_tlast  = s_tlast;
    assign m_tuser  = s_tuser;

    swa_classifier #(.INFO_BEAT(INFO_BEAT)) u_class (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .last     (s_tlast),
        .aux_flag (s_tuser[AUX_BIT]),
        .code     (s_tdata[CODE_W-1:0]),
        .cls      (cls)
    );

    swa_limit_reg #(.HAS_CTRL(HAS_CTRL), .FIELD_W(FIELD_W), .OUT_BPS(OUT_BPS)) u_limit (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .capture   (first_acc),
        .limit     (limit),
        .held      (held_limit)
    );

    swa_lane_map #(.IN_BPS(IN_BPS), .OUT_BPS(OUT_BPS), .LANES(LANES)) u_lanes (
        .din  (s_tdata),
        .dout (video_out)
    );

    swa_field_fix #(.W(PASS_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W), .NARROW(NARROW)) u_fix (
        .din   (s_tdata[PASS_W-1:0]),
        .en    (cls.field_beat),
        .limit (limit),
        .dout  (aux_fixed)
    );

    if (OUT_W > PASS_W) begin : g_aux_ext
        assign aux_out = {{(OUT_W-PASS_W){1'b0}}, aux_fixed};
    end else begin : g_aux_same
        assign aux_out = aux_fixed;
    end

    assign m_tdata = (cls.kind == PK_VIDEO) ? video_out : aux_out;
endmodule

// File: rtl/swa_adapter_chk.sv
module swa_adapter_chk
    import swa_pkg::*;
#(
    parameter int IN_BPS    = 10,
    parameter int OUT_BPS   = 8,
    parameter int PLANES    = 3,
    parameter int PIXELS    = 2,
    parameter int FIELD_LSB = 8,
    parameter int FIELD_W   = 5
) (
    input logic                             clk,
    input logic                             rst,
    input logic [IN_BPS*PLANES*PIXELS-1:0]  s_tdata,
    input logic                             s_tvalid,
    input logic                             s_tready,
    input logic                             s_tlast,
    input logic [OUT_BPS*PLANES*PIXELS-1:0] m_tdata,
    input pkt_kind_e                        kind,
    input logic                             in_first,
    input logic                             field_beat,
    input logic [FIELD_W-1:0]               held_limit
);
    localparam int LANES  = PLANES * PIXELS;
    localparam int PASS_W = min_i(IN_BPS * LANES, OUT_BPS * LANES);
    localparam bit NARROW = (IN_BPS > OUT_BPS);
    localparam int SH     = NARROW ? IN_BPS - OUT_BPS : 0;

    logic ok_lanes;
    always_comb begin
        ok_lanes = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (NARROW) begin
                if (m_tdata[k*OUT_BPS +: OUT_BPS] != OUT_BPS'(s_tdata[k*IN_BPS +: IN_BPS] >> SH))
                    ok_lanes = 1'b0;
            end else begin
                if ((m_tdata[k*OUT_BPS +: OUT_BPS] >> (OUT_BPS - IN_BPS)) != OUT_BPS'(s_tdata[k*IN_BPS +: IN_BPS]))
                    ok_lanes = 1'b0;
            end
        end
    end

    AST_VIDEO_MAP: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && kind == PK_VIDEO) |-> ok_lanes); // R1

    AST_AUX_KEEP: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && kind != PK_VIDEO && !field_beat) |-> (m_tdata[PASS_W-1:0] == s_tdata[PASS_W-1:0])); // R5

    AST_FIELD_BOUND: assert property (@(posedge clk) disable iff (rst)
        (NARROW && s_tvalid && field_beat) |-> (m_tdata[FIELD_LSB +: FIELD_W] <= FIELD_W'(OUT_BPS))); // R6

    AST_KIND_HELD: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready && !s_tlast) |=> (!in_first && kind == $past(kind))); // R4

    AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!in_first && !(s_tvalid && s_tready && s_tlast)) |=> $stable(held_limit)); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && !s_tready) |=> (in_first == $past(in_first))); // R10
endmodule

bind swa_adapter swa_adapter_chk #(
    .IN_BPS(IN_BPS), .OUT_BPS(OUT_BPS), .PLANES(PLANES), .PIXELS(PIXELS),
    .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .s_tdata    (s_tdata),
    .s_tvalid   (s_tvalid),
    .s_tready   (s_tready),
    .s_tlast    (s_tlast),
    .m_tdata    (m_tdata),
    .kind       (cls.kind),
    .in_first   (cls.first),
    .field_beat (cls.field_beat),
    .held_limit (held_limit)
);

// File: tb/swa_adapter_test.sv
module swa_adapter_test;
    localparam int CLK_PERIOD = 10;
    localparam int IW = 60, OW = 48;
    localparam int WIW = 48, WOW = 72;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [IW-1:0] s_tdata = '0;
    logic s_tvalid = 1'b0, s_tlast = 1'b0, m_tready = 1'b1, cfg_wr = 1'b0;
    logic [1:0] s_tuser = '0;
    logic [4:0] cfg_wdata = '0;
    logic s_tready, m_tvalid, m_tlast;
    logic [1:0] m_tuser;
    logic [OW-1:0] m_tdata;
    logic fx_s_tready, fx_m_tvalid, fx_m_tlast;
    logic [1:0] fx_m_tuser;
    logic [OW-1:0] fx_m_tdata;

    logic [WIW-1:0] w_tdata = '0;
    logic w_tvalid = 1'b0, w_tlast = 1'b0;
    logic [1:0] w_tuser = '0;
    logic w_s_tready, w_m_tvalid, w_m_tlast;
    logic [1:0] w_m_tuser;
    logic [WOW-1:0] w_m_tdata;

    swa_adapter uut (
        .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tlast(s_tlast), .s_tuser(s_tuser), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tlast(m_tlast), .m_tuser(m_tuser),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata));

    swa_adapter #(.HAS_CTRL(1'b0)) uut_fixed (
        .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(fx_s_tready),
        .s_tlast(s_tlast), .s_tuser(s_tuser), .m_tdata(fx_m_tdata), .m_tvalid(fx_m_tvalid),
        .m_tready(m_tready), .m_tlast(fx_m_tlast), .m_tuser(fx_m_tuser),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata));

    swa_adapter #(.IN_BPS(8), .OUT_BPS(12)) uut_wide (
        .clk(clk), .rst(rst), .s_tdata(w_tdata), .s_tvalid(w_tvalid), .s_tready(w_s_tready),
        .s_tlast(w_tlast), .s_tuser(w_tuser), .m_tdata(w_m_tdata), .m_tvalid(w_m_tvalid),
        .m_tready(1'b1), .m_tlast(w_m_tlast), .m_tuser(w_m_tuser),
        .cfg_wr(1'b0), .cfg_wdata(5'd0));

    typedef struct {
        logic [OW-1:0] d;
        logic [OW-1:0] dfix;
        logic          last;
        logic [1:0]    user;
        string         req;
    } item_t;

    item_t q[$];
    int n_chk = 0, n_fail = 0;
    bit stall_en = 1'b0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [WOW-1:0] act, input logic [WOW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected values, derived from the requirements
    function automatic logic [OW-1:0] exp_narrow(input logic [IW-1:0] d);
        logic [OW-1:0] r;
        for (int k = 0; k < 6; k++) r[k*8 +: 8] = d[k*10 + 2 +: 8];
        return r;
    endfunction

    function automatic logic [WOW-1:0] exp_wide(input logic [WIW-1:0] d);
        logic [WOW-1:0] r;
        for (int k = 0; k < 6; k++) r[k*12 +: 12] = {d[k*8 +: 8], 4'h0};
        return r;
    endfunction

    function automatic logic [IW-1:0] count_pat(input int seed);
        logic [IW-1:0] r;
        for (int k = 0; k < 6; k++) r[k*10 +: 10] = 10'((k * 97 + seed * 13) % 1024);
        return r;
    endfunction

    function automatic logic [IW-1:0] with_field(input logic [IW-1:0] d, input logic [4:0] f);
        logic [IW-1:0] r;
        r = d;
        r[12:8] = f;
        return r;
    endfunction

    function automatic logic [OW-1:0] aux_exp(input logic [IW-1:0] d, input bit fld, input int lim);
        logic [OW-1:0] r;
        r = d[OW-1:0];
        if (fld && int'(d[12:8]) > lim) r[12:8] = 5'(lim);
        return r;
    endfunction

    // backpressure pattern, changed away from both sampling points
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2 m_tready = stall_en ? ((cyc % 3) == 0) : 1'b1;
    end

    task automatic send(input logic [IW-1:0] d, input logic [1:0] u, input bit last,
                        input logic [OW-1:0] e, input logic [OW-1:0] efix, input string req);
        item_t it;
        #1;
        cfg_wr = 1'b0;
        s_tdata = d; s_tuser = u; s_tlast = last; s_tvalid = 1'b1;
        it.d = e; it.dfix = efix; it.last = last; it.user = u; it.req = req;
        q.push_back(it);
        do @(posedge clk); while (!m_tready);
    endtask

    task automatic idle();
        #1;
        s_tvalid = 1'b0; cfg_wr = 1'b0;
        @(posedge clk);
    endtask

    task automatic cfg_write(input logic [4:0] v);
        #1;
        s_tvalid = 1'b0; cfg_wr = 1'b1; cfg_wdata = v;
        @(posedge clk);
    endtask

    // monitor: compares output against the front of the scoreboard
    always @(negedge clk) begin
        if (!rst && s_tvalid) begin
            chk(m_tvalid && fx_m_tvalid, "R9 valid", WOW'(m_tvalid), 1);
            if (q.size() == 0) begin
                chk(1'b0, "scoreboard underflow", 0, 1);
            end else if (!m_tready) begin
                chk(!s_tready && m_tdata == q[0].d, "R10 stalled beat", WOW'(m_tdata), WOW'(q[0].d));
            end else begin
                chk(m_tdata == q[0].d, q[0].req, WOW'(m_tdata), WOW'(q[0].d));
                chk(fx_m_tdata == q[0].dfix, {q[0].req, " R11 fixed"}, WOW'(fx_m_tdata), WOW'(q[0].dfix));
                chk(m_tlast == q[0].last && m_tuser == q[0].user && s_tready,
                    "R9 sideband", WOW'({m_tlast, m_tuser}), WOW'({q[0].last, q[0].user}));
                void'(q.pop_front());
            end
        end
    end

    task automatic wsend(input logic [WIW-1:0] d, input logic [1:0] u, input bit last,
                         input logic [WOW-1:0] e, input string req);
        #1;
        w_tdata = d; w_tuser = u; w_tlast = last; w_tvalid = 1'b1;
        @(negedge clk);
        chk(w_m_tdata == e && w_m_tvalid && w_m_tlast == last, req, w_m_tdata, e);
        @(posedge clk);
    endtask

    bit done = 1'b0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [IW-1:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!m_tvalid && s_tready == m_tready, "R9 reset state", WOW'({m_tvalid, s_tready}), WOW'({1'b0, m_tready}));
        @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk);

        // R1 R3: video packet, several patterns
        d = {15{4'hF}}; send(d, 2'b01, 0, exp_narrow(d), exp_narrow(d), "R1 all ones");
        d = {15{4'hA}}; send(d, 2'b00, 0, exp_narrow(d), exp_narrow(d), "R3 alternating");
        d = count_pat(1); send(d, 2'b00, 1, exp_narrow(d), exp_narrow(d), "R3 counting");
        idle();

        // R10: stalled video packet
        stall_en = 1'b1;
        for (int b = 0; b < 4; b++) begin
            d = count_pat(b + 5);
            send(d, 2'b00, b == 3, exp_narrow(d), exp_narrow(d), "R10 video under stall");
        end
        // R10: stalled first beat of an info packet, field still found on beat 1
        d = {56'h0, 4'h1}; send(d, 2'b10, 0, aux_exp(d, 0, 8), aux_exp(d, 0, 8), "R10 info head stalled");
        d = with_field(count_pat(3), 5'd10); send(d, 2'b00, 1, aux_exp(d, 1, 8), aux_exp(d, 1, 8), "R10 R6 field after stall");
        stall_en = 1'b0;
        idle(); idle();

        // R5 R6: other aux packet leaves same bits untouched
        d = {56'hABC, 4'h3}; send(d, 2'b10, 0, aux_exp(d, 0, 8), aux_exp(d, 0, 8), "R5 aux head");
        d = with_field({15{4'h5}}, 5'd31); send(d, 2'b00, 1, aux_exp(d, 0, 8), aux_exp(d, 0, 8), "R6 non-info field kept");

        // R6: info packet, clamp and keep
        d = {56'h0, 4'h1}; send(d, 2'b10, 0, aux_exp(d, 0, 8), aux_exp(d, 0, 8), "R6 info head");
        d = with_field(count_pat(9), 5'd10); send(d, 2'b00, 0, aux_exp(d, 1, 8), aux_exp(d, 1, 8), "R6 field 10 to 8");
        d = with_field(count_pat(9), 5'd10); send(d, 2'b00, 1, aux_exp(d, 0, 8), aux_exp(d, 0, 8), "R6 beat 2 untouched");
        d = {56'h0, 4'h1}; send(d, 2'b10, 0, aux_exp(d, 0, 8), aux_exp(d, 0, 8), "R6 info head");
        d = with_field(count_pat(2), 5'd5); send(d, 2'b00, 1, aux_exp(d, 1, 8), aux_exp(d, 1, 8), "R6 field 5 kept");

        // R8: write during a packet does not touch the packet in flight
        d = {56'h0, 4'h1}; send(d, 2'b10, 0, aux_exp(d, 0, 8), aux_exp(d, 0, 8), "R8 info head");
        cfg_write(5'd6);
        d = with_field(count_pat(4), 5'd10); send(d, 2'b00, 1, aux_exp(d, 1, 8), aux_exp(d, 1, 8), "R8 old limit in flight");
        d = {56'h0, 4'h1}; send(d, 2'b10, 0, aux_exp(d, 0, 6), aux_exp(d, 0, 8), "R8 info head");
        d = with_field(count_pat(4), 5'd10); send(d, 2'b00, 1, aux_exp(d, 1, 6), aux_exp(d, 1, 8), "R8 R11 new limit 6");
        // R8: register above OUT_BPS clamps to OUT_BPS
        cfg_write(5'd20);
        d = {56'h0, 4'h1}; send(d, 2'b10, 0, aux_exp(d, 0, 8), aux_exp(d, 0, 8), "R8 info head");
        d = with_field(count_pat(6), 5'd12); send(d, 2'b00, 1, aux_exp(d, 1, 8), aux_exp(d, 1, 8), "R8 clamp at 8");

        // R4: video packet with the info code in its first beat stays video
        d = {56'hFFF, 4'h1}; send(d, 2'b01, 0, exp_narrow(d), exp_narrow(d), "R4 video head with code");
        d = with_field({15{4'h3}}, 5'd31); send(d, 2'b00, 0, exp_narrow(d), exp_narrow(d), "R4 video beat 1");
        d = {15{4'h3}}; send(d, 2'b10, 1, exp_narrow(d), exp_narrow(d), "R4 aux flag mid packet ignored");
        idle(); idle();
        chk(q.size() == 0, "R9 scoreboard drained", WOW'(q.size()), 0);

        // widening instance: R2 R5 R7
        wsend({12{4'h9}}, 2'b01, 1, exp_wide({12{4'h9}}), "R2 pad video");
        wsend(48'h0123_4567_89AB, 2'b00, 1, exp_wide(48'h0123_4567_89AB), "R2 R3 pad counting");
        wsend({44'hDEF, 4'h1}, 2'b10, 0, {24'h0, 44'hDEF, 4'h1}, "R5 wide aux head");
        begin
            logic [WIW-1:0] wd;
            wd = {12{4'h6}}; wd[12:8] = 5'd10;
            wsend(wd, 2'b00, 1, {24'h0, wd}, "R7 field unchanged");
        end
        #1 w_tvalid = 1'b0;
        @(posedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule